// File: doc/BRIEF.md
# Paged Address Mapper with Switchable Map Sets

This block sits between an 8-bit CPU and a memory system that is larger than 64 KB. The 16-bit CPU address is cut into sixteen 4 KB pages. The page number selects one entry of the active map set, and that entry supplies a wider physical page number. The 12-bit page offset passes through untouched. Several complete map sets are held in the block at the same time. Software fills them ahead of time and moves between them by writing one select register, so a task switch costs a single bus write.

An optional first stage runs before the page lookup. It moves 256-byte page 0x00 (zero page) and page 0x01 (stack) to programmable 256-byte pages. The result of that stage then goes through the page translation. All configuration is held in a 32-byte register window at 0xDC80. Addresses in that window are never translated. The CPU writes and reads the window directly while its chip select is asserted.

Top module: `paged_mapper`

## Requirements
- R1: After reset, translation and both relocations are off, so `phys_addr` equals the CPU address zero-extended. The select registers, the bases and the enable register read 0. Entry p of every set reads back p.
- R2: While the translate bit (bit 0 of offset 0x14) is set and the address is outside the window, `phys_addr` is {entry[active set][page], addr[11:0]}. Here the page is bits 15:12 of the relocated address. While the bit is clear, `phys_addr` is the relocated address zero-extended.
- R3: Addresses 0xDC80–0xDC9F assert `win_hit` and always give `phys_addr` equal to the CPU address zero-extended, whatever the configuration.
- R4: Offsets 0x00–0x0F access the 16 entries of the edit set. 0x10 is the active-set select, 0x11 the edit-set select, 0x12 the zero-page base and 0x13 the stack base. 0x14 holds the enables: bit 0 translate, bit 1 zero-page relocate, bit 2 stack relocate. Every one of these reads back what was written.
- R5: A write to an entry changes only the set named by the edit-set select. Other sets keep their contents.
- R6: One write to 0x10 switches all 16 entries at once. The new set drives `phys_addr` from the cycle after the write. The active set changes on no other write.
- R7: With bit 1 of 0x14 set, an address with bits 15:8 = 0x00 has those bits replaced by the zero-page base. The low byte is kept.
- R8: With bit 2 of 0x14 set, an address with bits 15:8 = 0x01 has those bits replaced by the stack base. The relocated address is the one that is then page-translated.
- R9: Reads of offsets 0x15–0x1F return 0, and writes to them change nothing. Writes while `cpu_cs` is low change nothing. `cpu_rdata` is 0 while `cpu_cs` is low or the address is outside the window.
- R10: Set-select writes keep only the low log2(NUM_SETS) bits, and the enable register keeps only bits 2:0. Read-back shows the kept bits with zeros above.
- R11: Different entries, in the same set or in different sets, may hold the same physical page number. Each of them then maps to that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_cs | input | 1 | Chip select for the register window |
| cpu_rdata | output | 8 | Register read data |
| win_hit | output | 1 | Address is inside the register window |
| phys_addr | output | 20 | Translated physical address |

## Verification
A corrupted entry, base or enable bit shows up only when an address that uses it is presented. Translation is combinational, so the fault appears in `phys_addr` in that same cycle. The bench therefore sends mixed addresses after every register write: random pages, zero page, stack and the window. A wrong active or edit select shows in the cycle after the write that set it, either as a whole set mapping wrongly or as an entry read back from the wrong set.

// File: rtl/paged_mapper_pkg.sv
package paged_mapper_pkg;
    localparam int unsigned WIN_AW = 5;
    localparam logic [4:0] OFF_ACT  = 5'h10;
    localparam logic [4:0] OFF_EDT  = 5'h11;
    localparam logic [4:0] OFF_ZPB  = 5'h12;
    localparam logic [4:0] OFF_STB  = 5'h13;
    localparam logic [4:0] OFF_EN   = 5'h14;
    localparam int unsigned EN_XL   = 0;
    localparam int unsigned EN_ZP   = 1;
    localparam int unsigned EN_STK  = 2;
    localparam int unsigned EN_W    = 3;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import paged_mapper_pkg::*;
#(
    parameter int unsigned NUM_SETS = 4,
    parameter int unsigned PPN_W    = 8,
    localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_en,
    input  logic                        we,
    input  logic [WIN_AW-1:0]           off,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    output logic [15:0][PPN_W-1:0]      act_map,
    output logic [7:0]                  zp_base,
    output logic [7:0]                  stk_base,
    output logic [EN_W-1:0]             en_bits
);
    typedef struct packed {
        logic [NUM_SETS-1:0][15:0][PPN_W-1:0] ent;
        logic [SET_W-1:0]                     act;
        logic [SET_W-1:0]                     edt;
        logic [7:0]                           zpb;
        logic [7:0]                           stb;
        logic [EN_W-1:0]                      en;
    } state_t;

    state_t st_d, st_q;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int k = 0; k < NUM_SETS; k++) begin
            for (int p = 0; p < 16; p++) begin
                s.ent[k][p] = PPN_W'(p);
            end
        end
        return s;
    endfunction

    logic wr;
    assign wr = acc_en && we;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (off[4] == 1'b0) begin
                st_d.ent[st_q.edt][off[3:0]] = wdata[PPN_W-1:0];
            end else begin
                case (off)
                    OFF_ACT: st_d.act = wdata[SET_W-1:0];
                    OFF_EDT: st_d.edt = wdata[SET_W-1:0];
                    OFF_ZPB: st_d.zpb = wdata;
                    OFF_STB: st_d.stb = wdata;
                    OFF_EN:  st_d.en  = wdata[EN_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (acc_en) begin
            if (off[4] == 1'b0) begin
                rdata = 8'(st_q.ent[st_q.edt][off[3:0]]);
            end else begin
                case (off)
                    OFF_ACT: rdata = 8'(st_q.act);
                    OFF_EDT: rdata = 8'(st_q.edt);
                    OFF_ZPB: rdata = st_q.zpb;
                    OFF_STB: rdata = st_q.stb;
                    OFF_EN:  rdata = 8'(st_q.en);
                    default: rdata = '0;
                endcase
            end
        end
    end

    assign act_map  = st_q.ent[st_q.act];
    assign zp_base  = st_q.zpb;
    assign stk_base = st_q.stb;
    assign en_bits  = st_q.en;

    // The active set moves only on a write to its select register
    assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && off == OFF_ACT) |=> $stable(st_q.act));

    // Editing an inactive set leaves the live map untouched
    assert_edit_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off[4] == 1'b0 && st_q.edt != st_q.act) |=> $stable(act_map));

    // Unused offsets change no state
    assert_unused_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off > OFF_EN) |=> $stable(st_q));
endmodule

// File: rtl/mapper_reloc.sv
module mapper_reloc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [7:0]  zp_base,
    input  logic [7:0]  stk_base,
    input  logic        zp_en,
    input  logic        stk_en,
    output logic [15:0] raddr
);
    always_comb begin
        raddr = addr;
        if (zp_en && addr[15:8] == 8'h00)       raddr = {zp_base, addr[7:0]};
        else if (stk_en && addr[15:8] == 8'h01) raddr = {stk_base, addr[7:0]};
    end

    // Relocation keeps the byte within the 256-byte page
    assert_low_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        raddr[7:0] == addr[7:0]);

    // Addresses above the stack page are never relocated
    assert_upper_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:9] != 7'd0) |-> raddr == addr);
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate #(
    parameter int unsigned PPN_W = 8,
    localparam int unsigned PA_W = PPN_W + 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            raddr,
    input  logic [15:0][PPN_W-1:0] act_map,
    input  logic                   xl_en,
    output logic [PA_W-1:0]        phys
);
    logic [15:0] page_hit;
    logic [PPN_W-1:0] ppn;

    for (genvar p = 0; p < 16; p++) begin : g_dec
        assign page_hit[p] = (raddr[15:12] == 4'(p));
    end

    always_comb begin
        ppn = '0;
        for (int p = 0; p < 16; p++) begin
            if (page_hit[p]) ppn = act_map[p];
        end
        phys = xl_en ? {ppn, raddr[11:0]} : PA_W'(raddr);
    end

    assert_one_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(page_hit) == 1);

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phys[11:0] == raddr[11:0]);
endmodule

// File: rtl/paged_mapper.sv
module paged_mapper
    import paged_mapper_pkg::*;
#(
    parameter int unsigned NUM_SETS = 4,
    parameter int unsigned PPN_W    = 8,
    parameter logic [15:0] REG_BASE = 16'hDC80,
    localparam int unsigned PA_W    = PPN_W + 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     cpu_addr,
    input  logic [7:0]      cpu_wdata,
    input  logic            cpu_we,
    input  logic            cpu_cs,
    output logic [7:0]      cpu_rdata,
    output logic            win_hit,
    output logic [PA_W-1:0] phys_addr
);
    logic [15:0][PPN_W-1:0] act_map;
    logic [7:0]             zp_base, stk_base;
    logic [EN_W-1:0]        en_bits;
    logic [15:0]            raddr;
    logic [PA_W-1:0]        xl_phys;
    logic                   acc_en;

    assign win_hit = (cpu_addr[15:WIN_AW] == REG_BASE[15:WIN_AW]);
    assign acc_en  = cpu_cs && win_hit;

    mapper_regs #(.NUM_SETS(NUM_SETS), .PPN_W(PPN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .we(cpu_we),
        .off(cpu_addr[WIN_AW-1:0]), .wdata(cpu_wdata), .rdata(cpu_rdata),
        .act_map(act_map), .zp_base(zp_base), .stk_base(stk_base),
        .en_bits(en_bits)
    );

    mapper_reloc u_reloc (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .zp_base(zp_base),
        .stk_base(stk_base), .zp_en(en_bits[EN_ZP]), .stk_en(en_bits[EN_STK]),
        .raddr(raddr)
    );

    mapper_xlate #(.PPN_W(PPN_W)) u_xlate (
        .clk(clk), .rst_n(rst_n), .raddr(raddr), .act_map(act_map),
        .xl_en(en_bits[EN_XL]), .phys(xl_phys)
    );

    assign phys_addr = win_hit ? PA_W'(cpu_addr) : xl_phys;

    // Window accesses bypass the mapping
    assert_window_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> phys_addr == PA_W'(cpu_addr));

    // Nothing selected means nothing read
    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> cpu_rdata == 8'd0);

    // With every stage off the address passes straight through
    assert_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_bits == '0) |-> phys_addr == PA_W'(cpu_addr));
endmodule

// File: tb/paged_mapper_test.sv
`timescale 1ns/1ps
module paged_mapper_test;
    localparam int NS = 4;
    localparam logic [15:0] BASE = 16'hDC80;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_we = 0;
    logic        cpu_cs = 0;
    logic [7:0]  cpu_rdata;
    logic        win_hit;
    logic [19:0] phys_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m_ent [NS][16];
    int         m_act, m_edt;
    logic [7:0] m_zpb, m_stb;
    logic [2:0] m_en;

    paged_mapper uut (.*);

    always #2 clk = ~clk;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [19:0] exp_phys(logic [15:0] a);
        logic [15:0] r;
        if (a[15:5] == BASE[15:5]) return {4'h0, a};
        r = a;
        if (m_en[1] && a[15:8] == 8'h00) r = {m_zpb, a[7:0]};
        else if (m_en[2] && a[15:8] == 8'h01) r = {m_stb, a[7:0]};
        if (m_en[0]) return {m_ent[m_act][r[15:12]], r[11:0]};
        return {4'h0, r};
    endfunction

    task automatic wr(logic [4:0] off, logic [7:0] d, logic cs = 1'b1);
        @(negedge clk);
        cpu_addr = BASE + 16'(off); cpu_wdata = d; cpu_we = 1; cpu_cs = cs;
        @(posedge clk); #1;
        cpu_we = 0; cpu_cs = 0;
        if (cs) begin
            if (off < 5'h10) m_ent[m_edt][off[3:0]] = d;
            else case (off)
                5'h10: m_act = int'(d[1:0]);
                5'h11: m_edt = int'(d[1:0]);
                5'h12: m_zpb = d;
                5'h13: m_stb = d;
                5'h14: m_en  = d[2:0];
                default: ;
            endcase
        end
    endtask

    task automatic rd(string req, logic [4:0] off, logic [7:0] exp);
        @(negedge clk);
        cpu_addr = BASE + 16'(off); cpu_we = 0; cpu_cs = 1;
        #1 chk(req, 32'(cpu_rdata), 32'(exp));
        cpu_cs = 0;
    endtask

    task automatic pa(string req, logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_cs = 0; cpu_we = 0;
        #1 chk(req, 32'(phys_addr), 32'(exp_phys(a)));
        chk("R3 win_hit", 32'(win_hit), 32'(a[15:5] == BASE[15:5]));
    endtask

    function automatic logic [15:0] rand_addr();
        case ($urandom % 5)
            0: return {8'h00, 8'($urandom)};
            1: return {8'h01, 8'($urandom)};
            2: return BASE + 16'($urandom % 32);
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        #800000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < NS; k++)
            for (int p = 0; p < 16; p++) m_ent[k][p] = 8'(p);
        m_act = 0; m_edt = 0; m_zpb = 0; m_stb = 0; m_en = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;

        // R1: reset state
        pa("R1 reset phys", 16'h1234);
        pa("R1 reset phys zp", 16'h0042);
        for (int o = 16; o <= 20; o++) rd("R1 reset reg", 5'(o), 8'h00);
        for (int k = 0; k < NS; k++) begin
            wr(5'h11, 8'(k));
            for (int p = 0; p < 16; p++) rd("R1 identity entry", 5'(p), 8'(p));
        end

        // R4/R5: fill set 2, check set 0 untouched
        wr(5'h11, 8'd2);
        for (int p = 0; p < 16; p++) wr(5'(p), 8'(8'h80 + p));
        wr(5'h11, 8'd0);
        rd("R5 other set kept", 5'h3, 8'h03);
        wr(5'h11, 8'd2);
        rd("R4 entry readback", 5'h3, 8'h83);

        // R2/R6: enable translation, switch set, effective next cycle
        wr(5'h14, 8'h01);
        pa("R2 set0 translate", 16'h5ABC);
        wr(5'h10, 8'd2);
        pa("R6 switched set", 16'h5ABC);
        chk("R6 expected page", 32'(phys_addr), 32'h85ABC);
        rd("R4 active readback", 5'h10, 8'd2);

        // R7/R8: relocation feeds translation
        wr(5'h12, 8'h35); wr(5'h13, 8'hF1); wr(5'h14, 8'h07);
        pa("R7 zp relocate", 16'h0010);
        chk("R7 expected", 32'(phys_addr), 32'h83510);
        pa("R8 stack relocate", 16'h01FF);
        chk("R8 expected", 32'(phys_addr), 32'h8F1FF);
        pa("R8 non-stack", 16'h0200);

        // R3: window never translated
        pa("R3 window pass", 16'hDC85);
        pa("R3 window end", 16'hDC9F);
        pa("R3 just outside", 16'hDCA0);

        // R9: unused offsets and writes without chip select
        wr(5'h1A, 8'hFF);
        rd("R9 unused reads 0", 5'h1A, 8'h00);
        rd("R9 unused no side effect", 5'h14, 8'h07);
        wr(5'h10, 8'd1, 1'b0);
        rd("R9 cs low ignored", 5'h10, 8'd2);
        @(negedge clk); cpu_addr = BASE + 16'h10; cpu_cs = 0;
        #1 chk("R9 rdata idle", 32'(cpu_rdata), 0);

        // R10: field masking
        wr(5'h10, 8'hFF);
        rd("R10 act masked", 5'h10, 8'd3);
        wr(5'h14, 8'hF9);
        rd("R10 en masked", 5'h14, 8'h01);

        // R11: shared physical page
        wr(5'h11, 8'd3);
        wr(5'h4, 8'h77); wr(5'h9, 8'h77);
        wr(5'h11, 8'd1);
        wr(5'h4, 8'h77);
        pa("R11 shared a", 16'h4001);
        chk("R11 expect a", 32'(phys_addr), 32'h77001);
        pa("R11 shared b", 16'h9001);
        chk("R11 expect b", 32'(phys_addr), 32'h77001);
        wr(5'h10, 8'd1);
        pa("R11 shared other set", 16'h4001);
        chk("R11 expect c", 32'(phys_addr), 32'h77001);

        // Random mix: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < 400; i++) begin
            logic [4:0] off;
            off = ($urandom % 8 == 0) ? 5'(16 + $urandom % 16) : 5'($urandom % 21);
            wr(off, 8'($urandom));
            pa("R2 random phys", rand_addr());
            pa("R2 random phys", rand_addr());
            if (off <= 5'h14) begin
                logic [7:0] e;
                if (off < 5'h10) e = m_ent[m_edt][off[3:0]];
                else case (off)
                    5'h10: e = 8'(m_act);
                    5'h11: e = 8'(m_edt);
                    5'h12: e = m_zpb;
                    5'h13: e = m_stb;
                    default: e = 8'(m_en);
                endcase
                rd("R4 random readback", off, e);
            end else begin
                rd("R9 random unused", off, 8'h00);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule